// File: doc/BRIEF.md
# Fixed-Point Second-Order Recursive Filter with Serial Coefficient Preload

This block runs a second-order recursive (IIR) filter over a single stream of signed samples. There is one port for incoming samples. Reset empties the filter history and leaves the block in a loading state. In that state the port carries five coefficients, one on each clock, in this order: the three feed-forward taps b0, b1, b2 and then the two feedback taps a1, a2. After the fifth coefficient the block moves to its running state. From then on every word on the same port is a data sample, and each sample yields one filtered output word.

Every quantity uses one signed two's-complement word of W bits: 2 integer bits and F = W-2 fractional bits. A raw value r means r / 2^F. The output is y[n] = b0·x[n] + b1·x[n-1] + b2·x[n-2] − a1·y[n-1] − a2·y[n-2] (direct form I). Each product is formed at full precision and realigned to the common binary point by an arithmetic right shift of F bits, which rounds toward minus infinity. The five realigned terms are added at a wider width and the sum is clamped to the W-bit range. The clamped value goes to the output register and is also the fed-back y history.

The control state machine has two states. LOAD captures one coefficient per clock into slot 0 to 4. It takes the transition LOAD_DONE to RUN on the clock that fills slot 4. RUN filters every clock until reset. Reset is the only transition out of RUN, and it returns the machine to LOAD at slot 0.

Top module: `biquad_preload_filter`

## Requirements
- R1: During the five loading clocks after reset, the output stays at 0.
- R2: The five words that arrive in the loading clocks are stored, in arrival order, as b0, b1, b2, a1, a2. They do not change again until the next reset.
- R3: Each data word that arrives from the sixth clock after reset onward produces its output value in the output register at the same clock edge that accepts it: one cycle of latency. Zero input with zero history gives zero output.
- R4: Every value uses signed 2.F format with F = W-2. Each product is reduced to 2.F by an arithmetic right shift of F bits, which rounds toward minus infinity (for example 0.5 × (−1 LSB) yields −1 LSB).
- R5: A sum above the largest representable value gives 2^(W-1)−1 on the output.
- R6: A sum below the smallest representable value gives −2^(W-1) on the output.
- R7: Reset clears the input and output history to zero, so the first outputs after a new load depend only on new samples.
- R8: While reset is asserted the output register holds 0.
- R9: The feedback terms use the clamped past outputs y[n-1] and y[n-2], subtracted after scaling by a1 and a2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sample_in | input | W (10) | Coefficient word while loading, data sample while running, signed 2.F |
| sample_out | output | W (10) | Filtered sample, signed 2.F, registered |

## Verification
Each coefficient word is accepted at a rising edge, and the output must still read zero just after that edge. Each data word is driven one nanosecond after a rising edge. The bench reads its filtered result one nanosecond after the next rising edge, because only the output register lies between input and output. The bench model advances its own x and y history once per accepted sample, so every comparison lines up with exactly one edge. The sweeps cover every input value against several single-tap gains, then long pseudo-random runs with all five taps active.

// File: rtl/bqf_pkg.sv
package bqf_pkg;
    // Control states of the preload sequencer
    typedef enum logic {
        ST_LOAD = 1'b0,
        ST_RUN  = 1'b1
    } bqf_state_e;

    // Number of coefficients of one second-order section
    localparam int BQF_NUM_COEF = 5;
    // Index of the first feedback coefficient (a1); taps at or above it are subtracted
    localparam int BQF_FIRST_FB = 3;
endpackage

// File: rtl/bqf_coef_ctrl.sv
module bqf_coef_ctrl
    import bqf_pkg::*;
#(
    parameter int W  = 10,
    parameter int NC = BQF_NUM_COEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [W-1:0]         din,
    output logic                 run,
    output logic [NC*W-1:0]      coef_flat
);
    localparam int IW = $clog2(NC);
    localparam logic [IW-1:0] LAST_IDX = IW'(NC - 1);

    bqf_state_e     state, state_nxt;
    logic [IW-1:0]  slot;

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_LOAD: if (slot == LAST_IDX) state_nxt = ST_RUN;   // LOAD_DONE
            ST_RUN:  state_nxt = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_LOAD;
        else     state <= state_nxt;
    end

    // Outputs: slot counter and coefficient capture
    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
        end else begin
            unique case (state)
                ST_LOAD: begin
                    coef_flat[slot*W +: W] <= din;
                    if (slot != LAST_IDX) slot <= slot + 1'b1;
                end
                ST_RUN: ;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_LOAD: run = 1'b0;
            ST_RUN:  run = 1'b1;
        endcase
    end
endmodule

// File: rtl/bqf_term.sv
module bqf_term #(
    parameter int W = 10
) (
    input  logic signed [W-1:0] coef,
    input  logic signed [W-1:0] operand,
    output logic signed [W+1:0] term
);
    localparam int F = W - 2;

    logic signed [2*W-1:0] prod;

    // Full 4.(2F) product; dropping F low bits is an arithmetic shift (floor)
    assign prod = coef * operand;
    assign term = prod[2*W-1:F];
endmodule

// File: rtl/bqf_datapath.sv
module bqf_datapath
    import bqf_pkg::*;
#(
    parameter int W  = 10,
    parameter int NC = BQF_NUM_COEF
) (
    input  logic [NC*W-1:0]      coef_flat,
    input  logic signed [W-1:0]  x0,
    input  logic signed [W-1:0]  x1,
    input  logic signed [W-1:0]  x2,
    input  logic signed [W-1:0]  y1,
    input  logic signed [W-1:0]  y2,
    output logic signed [W-1:0]  y_sat
);
    localparam int TW = W + 2;
    localparam int GW = 3;
    localparam int SW = TW + GW;
    localparam logic signed [SW-1:0] SAT_HI = {{(SW-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [SW-1:0] SAT_LO = {{(SW-W+1){1'b1}}, {(W-1){1'b0}}};

    logic signed [W-1:0]  opnd  [NC];
    logic signed [TW-1:0] term  [NC];
    logic signed [SW-1:0] sterm [NC];
    logic signed [SW-1:0] acc;

    assign opnd[0] = x0;
    assign opnd[1] = x1;
    assign opnd[2] = x2;
    assign opnd[3] = y1;
    assign opnd[4] = y2;

    for (genvar k = 0; k < NC; k++) begin : g_tap
        logic signed [SW-1:0] ext;
        bqf_term #(.W(W)) term_i (
            .coef    (coef_flat[k*W +: W]),
            .operand (opnd[k]),
            .term    (term[k])
        );
        assign ext = {{GW{term[k][TW-1]}}, term[k]};
        if (k < BQF_FIRST_FB) begin : g_ff
            assign sterm[k] = ext;
        end else begin : g_fb
            assign sterm[k] = -ext;
        end
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < NC; k++) acc = acc + sterm[k];
    end

    always_comb begin
        if (acc > SAT_HI)      y_sat = SAT_HI[W-1:0];
        else if (acc < SAT_LO) y_sat = SAT_LO[W-1:0];
        else                   y_sat = acc[W-1:0];
    end
endmodule

// File: rtl/biquad_preload_filter.sv
module biquad_preload_filter
    import bqf_pkg::*;
#(
    parameter int W  = 10,
    parameter int NC = BQF_NUM_COEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] sample_in,
    output logic signed [W-1:0] sample_out
);
    logic                run_w;
    logic [NC*W-1:0]     coef_w;
    logic signed [W-1:0] x_d1, x_d2, y_d1, y_d2, y_new;

    bqf_coef_ctrl #(.W(W), .NC(NC)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .din       (sample_in),
        .run       (run_w),
        .coef_flat (coef_w)
    );

    bqf_datapath #(.W(W), .NC(NC)) dp_i (
        .coef_flat (coef_w),
        .x0        (sample_in),
        .x1        (x_d1),
        .x2        (x_d2),
        .y1        (y_d1),
        .y2        (y_d2),
        .y_sat     (y_new)
    );

    // History and output register
    always_ff @(posedge clk) begin
        if (rst) begin
            x_d1       <= '0;
            x_d2       <= '0;
            y_d1       <= '0;
            y_d2       <= '0;
            sample_out <= '0;
        end else if (run_w) begin
            x_d1       <= sample_in;
            x_d2       <= x_d1;
            y_d1       <= y_new;
            y_d2       <= y_d1;
            sample_out <= y_new;
        end else begin
            sample_out <= '0;
        end
    end
endmodule

// File: rtl/bqf_checker.sv
module bqf_checker #(
    parameter int W  = 10,
    parameter int NC = 5
) (
    input logic                clk,
    input logic                rst,
    input logic signed [W-1:0] sample_in,
    input logic signed [W-1:0] sample_out,
    input logic                run,
    input logic [NC*W-1:0]     coef_flat
);
    localparam int CW = $clog2(NC + 1);
    localparam logic [CW-1:0] NC_C = CW'(NC);

    logic [CW-1:0]       ld_seen;
    logic signed [W-1:0] xin_d1, xin_d2, out_d1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_seen <= '0;
            xin_d1  <= '0;
            xin_d2  <= '0;
            out_d1  <= '0;
        end else begin
            if (ld_seen < NC_C) ld_seen <= ld_seen + 1'b1;
            if (run) begin
                xin_d1 <= sample_in;
                xin_d2 <= xin_d1;
            end
            out_d1 <= sample_out;
        end
    end

    // R1
    load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_seen < NC_C) |=> (sample_out == '0));

    // R8
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (sample_out == '0));

    // R2
    coef_hold_chk: assert property (@(posedge clk) disable iff (rst)
        run |=> $stable(coef_flat));

    // R3
    run_entry_chk: assert property (@(posedge clk) disable iff (rst)
        run == (ld_seen == NC_C));

    // R3
    zero_rest_chk: assert property (@(posedge clk) disable iff (rst)
        (run && sample_in == '0 && xin_d1 == '0 && xin_d2 == '0 &&
         sample_out == '0 && out_d1 == '0) |=> (sample_out == '0));
endmodule

bind biquad_preload_filter bqf_checker #(.W(W), .NC(NC)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .sample_in  (sample_in),
    .sample_out (sample_out),
    .run        (run_w),
    .coef_flat  (coef_w)
);

// File: tb/biquad_preload_filter_tb_top.sv
`timescale 1ns/1ps
module biquad_preload_filter_tb_top;
    localparam int W    = 10;
    localparam int F    = W - 2;
    localparam int MAXV = (1 << (W - 1)) - 1;
    localparam int MINV = -(1 << (W - 1));

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic signed [W-1:0] sample_in = '0;
    logic signed [W-1:0] sample_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int mc [5];
    int mx1, mx2, my1, my2;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    biquad_preload_filter #(.W(W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .sample_in  (sample_in),
        .sample_out (sample_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        if (v > MAXV) return MAXV;
        if (v < MINV) return MINV;
        return v;
    endfunction

    task automatic model(input int x, output int y);
        int acc;
        acc = ((mc[0] * x) >>> F) + ((mc[1] * mx1) >>> F) + ((mc[2] * mx2) >>> F)
            - ((mc[3] * my1) >>> F) - ((mc[4] * my2) >>> F);
        y = sat(acc);
        mx2 = mx1; mx1 = x; my2 = my1; my1 = y;
    endtask

    function automatic int rnd_word();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return int'($signed(lfsr[W-1:0]));
    endfunction

    // Reset, then load b0,b1,b2,a1,a2
    task automatic session(input int c0, input int c1, input int c2, input int c3, input int c4);
        int cs [5];
        cs = '{c0, c1, c2, c3, c4};
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R8 output zero in reset", int'(sample_out), 0);
        rst = 1'b0;
        for (int k = 0; k < 5; k++) begin
            sample_in = cs[k][W-1:0];
            @(posedge clk);
            #1;
            chk("R1 output zero while loading", int'(sample_out), 0);
        end
        mc = cs;
        mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
    endtask

    // Drive one data sample and compare with the model one edge later
    task automatic push(input int x, input string tag, output int got);
        int exp;
        sample_in = x[W-1:0];
        model(x, exp);
        @(posedge clk);
        #1;
        got = int'(sample_out);
        chk(tag, got, exp);
    endtask

    task automatic push_lit(input int x, input string tag, input int lit);
        int got;
        push(x, tag, got);
        chk(tag, got, lit);
    endtask

    initial begin
        int got;
        int gains [4];
        gains = '{MAXV, MINV, 128, -256};

        // R2: impulse through feed-forward taps shows b0,b1,b2 in order
        session(128, 64, -64, 0, 0);
        push_lit(256, "R2 b0 slot", 128);
        push_lit(0,   "R2 b1 slot", 64);
        push_lit(0,   "R2 b2 slot", -64);
        push_lit(0,   "R3 response ends", 0);
        push_lit(0,   "R3 zero in zero out", 0);

        // R9: a1 = -0.5 gives a decaying geometric response
        session(256, 0, 0, -128, 0);
        push_lit(256, "R9 a1 step0", 256);
        push_lit(0,   "R9 a1 step1", 128);
        push_lit(0,   "R9 a1 step2", 64);
        push_lit(0,   "R9 a1 step3", 32);

        // R9/R2: a2 slot is the last loaded word
        session(256, 0, 0, 0, 128);
        push_lit(256, "R9 a2 step0", 256);
        push_lit(0,   "R9 a2 step1", 0);
        push_lit(0,   "R9 a2 step2", -128);

        // R4: floor rounding of rescaled products
        session(128, 0, 0, 0, 0);
        push_lit(1,  "R4 floor +1", 0);
        push_lit(-1, "R4 floor -1", -1);
        push_lit(3,  "R4 floor +3", 1);
        push_lit(-3, "R4 floor -3", -2);

        // R5/R6: clamping
        session(MAXV, 0, 0, 0, 0);
        push_lit(MAXV, "R5 positive clamp", MAXV);
        push_lit(MINV, "R6 negative clamp", MINV);
        push_lit(0,    "R3 back to zero", 0);

        // R7: history cleared by a new reset after activity
        session(256, 256, 256, 0, 0);
        for (int i = 0; i < 6; i++) push(300 - 40 * i, "R7 prior activity", got);
        session(0, 256, 0, -200, 100);
        push_lit(0,   "R7 history cleared", 0);
        push_lit(0,   "R7 history cleared 2", 0);
        push_lit(100, "R7 fresh sample", 0);

        // Exhaustive single-tap sweep over every input word (R4, R5, R6)
        foreach (gains[g]) begin
            session(gains[g], 0, 0, 0, 0);
            for (int x = MINV; x <= MAXV; x++) push(x, "R4 single-tap sweep", got);
        end

        // Full-section pseudo-random sweeps (R3, R9)
        for (int s = 0; s < 8; s++) begin
            session(rnd_word(), rnd_word(), rnd_word(), rnd_word() / 2, rnd_word() / 2);
            for (int i = 0; i < 150; i++) push(rnd_word(), "R9 full section sweep", got);
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule